// File: doc/BRIEF.md
# Compare Latch and Branch Resolver

This block sits beside an instruction decoder and resolves conditional branches for a core whose compare instruction produces no flags. A compare strobe captures two 32-bit register values into a pair of operand latches. A later branch strobe carries the branch's own program counter, a 4-bit condition code and a 10-bit offset. The block tests the selected relation on the stored operands, either signed or unsigned, and reports whether the branch is taken and which program counter follows it.

The result is registered and appears one clock after the branch strobe. When a compare and a branch arrive in the same cycle, the branch is tested against the operands that were latched before that cycle. Condition codes with no defined relation are flagged as illegal. For those codes the reported program counter stays at the branch's own address, so a trap handler can find the faulting instruction.

Top module: `bru_branch_resolver`

## Requirements
- R1: A synchronous active-high reset clears both operand latches to zero and drops `res_valid`, `res_taken` and `res_illegal`. A branch with code 0 (equal) issued straight after reset is therefore taken.
- R2: On `cmp_valid` the block stores `cmp_a` as operand A and `cmp_b` as operand B, and every later branch compares A against B. A compare with no branch produces no result (`res_valid` stays 0).
- R3: If `cmp_valid` and `br_valid` are high in the same cycle, the branch uses the operands held before that cycle, and the new operands apply from the next branch on.
- R4: Code 0 is taken when A equals B. Code 1 is taken when A differs from B.
- R5: The signed relations, with both operands read as two's complement, are: code 2 A<B, code 3 A>B, code 6 A>=B, code 7 A<=B.
- R6: The unsigned relations are: code 4 A<B, code 5 A>B, code 8 A>=B, code 9 A<=B.
- R7: A taken branch reports `res_next_pc` = `br_pc` + 2 + (the 10-bit `br_offset` sign-extended to 32 bits and shifted left by one), wrapping modulo 2^32.
- R8: A legal branch that is not taken reports `res_next_pc` = `br_pc` + 2, wrapping modulo 2^32.
- R9: Codes 10 to 15 set `res_illegal` to 1, set `res_taken` to 0 and report `res_next_pc` = `br_pc`.
- R10: `res_valid` is high for exactly the one cycle after each cycle with `br_valid` high, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Capture the compare operands this cycle |
| cmp_a | input | 32 | First compare operand (A) |
| cmp_b | input | 32 | Second compare operand (B) |
| br_valid | input | 1 | Resolve a branch this cycle |
| br_pc | input | 32 | Address of the branch instruction |
| br_cond | input | 4 | Condition code, 0 to 9 legal |
| br_offset | input | 10 | Signed offset in halfwords |
| res_valid | output | 1 | Result fields valid this cycle |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Program counter that follows the branch |
| res_illegal | output | 1 | Condition code is undefined |

## Verification
The assertions assume that the strobes and the branch fields carry known values whenever reset is low. The address checks use the `br_pc` value from the strobe cycle, so they assume the fields are sampled only in that cycle and not held across cycles. The stimulus drives every input to a defined value from time zero and changes it only on the falling clock edge. It draws operands from a mix that often makes A equal to B or puts them on either side of the sign boundary, so that the signed and unsigned relations disagree.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int DATA_W  = 32;
    localparam int PC_W    = 32;
    localparam int OFF_W   = 10;
    localparam int COND_W  = 4;
    localparam int NUM_REL = 10;
    localparam int NUM_CODE = 1 << COND_W;
    localparam int INSN_BYTES = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [COND_W-1:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_SLT = 4'd2,
        REL_SGT = 4'd3,
        REL_ULT = 4'd4,
        REL_UGT = 4'd5,
        REL_SGE = 4'd6,
        REL_SLE = 4'd7,
        REL_UGE = 4'd8,
        REL_ULE = 4'd9
    } rel_code_e;

    typedef struct packed {
        word_t a;
        word_t b;
    } operand_pair_t;

    typedef struct packed {
        pc_t                pc;
        logic [COND_W-1:0]  code;
        off_t               off;
    } branch_req_t;

    typedef struct packed {
        logic taken;
        logic illegal;
        pc_t  next_pc;
    } branch_res_t;

    // Evaluate one defined relation of A against B.
    function automatic logic eval_relation(input rel_code_e code, input word_t a, input word_t b);
        logic r;
        case (code)
            REL_EQ:  r = (a == b);
            REL_NE:  r = (a != b);
            REL_SLT: r = ($signed(a) <  $signed(b));
            REL_SGT: r = ($signed(a) >  $signed(b));
            REL_ULT: r = (a <  b);
            REL_UGT: r = (a >  b);
            REL_SGE: r = ($signed(a) >= $signed(b));
            REL_SLE: r = ($signed(a) <= $signed(b));
            REL_UGE: r = (a >= b);
            REL_ULE: r = (a <= b);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Halfword offset to a byte displacement.
    function automatic pc_t offset_to_bytes(input off_t off);
        pc_t ext;
        ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        return ext << 1;
    endfunction

endpackage

// File: rtl/bru_operand_latch.sv
module bru_operand_latch
    import bru_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  operand_pair_t din,
    output operand_pair_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= din;
        end
    end

    // R2
    load_captures_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (held == $past(din)));

    // R2
    hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(rst)) |=> $stable(held));

endmodule

// File: rtl/bru_relation_eval.sv
module bru_relation_eval
    import bru_pkg::*;
(
    input  operand_pair_t     ops,
    input  logic [COND_W-1:0] code,
    output logic              hit,
    output logic              undefined
);

    logic [NUM_CODE-1:0] rel_vec;

    for (genvar i = 0; i < NUM_CODE; i++) begin : g_rel
        if (i < NUM_REL) begin : g_def
            assign rel_vec[i] = eval_relation(rel_code_e'(i), ops.a, ops.b);
        end else begin : g_undef
            assign rel_vec[i] = 1'b0;
        end
    end

    assign undefined = (code >= COND_W'(NUM_REL));
    assign hit       = rel_vec[code] & ~undefined;

endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc
    import bru_pkg::*;
(
    input  pc_t  pc,
    input  off_t off,
    input  logic hit,
    input  logic undefined,
    output pc_t  next_pc
);

    pc_t seq_pc;
    pc_t jump_pc;

    always_comb begin
        seq_pc  = pc + PC_W'(INSN_BYTES);
        jump_pc = seq_pc + offset_to_bytes(off);
        if (undefined) begin
            next_pc = pc;
        end else if (hit) begin
            next_pc = jump_pc;
        end else begin
            next_pc = seq_pc;
        end
    end

endmodule

// File: rtl/bru_branch_resolver.sv
module bru_branch_resolver
    import bru_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_valid,
    input  logic [31:0] cmp_a,
    input  logic [31:0] cmp_b,
    input  logic        br_valid,
    input  logic [31:0] br_pc,
    input  logic [3:0]  br_cond,
    input  logic [9:0]  br_offset,
    output logic        res_valid,
    output logic        res_taken,
    output logic [31:0] res_next_pc,
    output logic        res_illegal
);

    operand_pair_t cmp_in;
    operand_pair_t cmp_held;
    branch_req_t   req;
    branch_res_t   comb_res;
    branch_res_t   res_q;
    logic          valid_q;

    assign cmp_in = '{a: cmp_a, b: cmp_b};
    assign req    = '{pc: br_pc, code: br_cond, off: br_offset};

    bru_operand_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (cmp_valid),
        .din  (cmp_in),
        .held (cmp_held)
    );

    bru_relation_eval u_eval (
        .ops       (cmp_held),
        .code      (req.code),
        .hit       (comb_res.taken),
        .undefined (comb_res.illegal)
    );

    bru_target_calc u_tgt (
        .pc        (req.pc),
        .off       (req.off),
        .hit       (comb_res.taken),
        .undefined (comb_res.illegal),
        .next_pc   (comb_res.next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= br_valid;
            if (br_valid) begin
                res_q <= comb_res;
            end
        end
    end

    assign res_valid   = valid_q;
    assign res_taken   = res_q.taken;
    assign res_illegal = res_q.illegal;
    assign res_next_pc = res_q.next_pc;

    // R10
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> res_valid);

    // R10
    result_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(rst)) |-> $past(br_valid));

    // R9
    illegal_keeps_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_cond >= 4'd10) |=> (res_illegal && !res_taken && res_next_pc == $past(br_pc)));

    // R8
    fallthrough_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_cond < 4'd10) |=> (res_taken || res_next_pc == $past(br_pc) + 32'd2));

    // R9
    taken_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot0({res_taken, res_illegal}));

endmodule

// File: tb/sim_bru_branch_resolver.sv
module sim_bru_branch_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_pc = '0;
    logic [3:0]  br_cond = '0;
    logic [9:0]  br_offset = '0;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_next_pc;
    logic        res_illegal;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    logic [31:0] mdl_a = '0;
    logic [31:0] mdl_b = '0;

    always #5 clk = ~clk;

    bru_branch_resolver u0 (
        .clk(clk), .rst(rst),
        .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_valid(br_valid), .br_pc(br_pc), .br_cond(br_cond), .br_offset(br_offset),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_next_pc(res_next_pc), .res_illegal(res_illegal)
    );

    function automatic bit exp_taken(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $signed(a) <  $signed(b);
            4'd3: return $signed(a) >  $signed(b);
            4'd4: return a <  b;
            4'd5: return a >  b;
            4'd6: return $signed(a) >= $signed(b);
            4'd7: return $signed(a) <= $signed(b);
            4'd8: return a >= b;
            4'd9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_pc(input logic [3:0] c, input logic [31:0] pc,
                                           input logic [9:0] off, input bit tk);
        logic [31:0] disp;
        disp = {{22{off[9]}}, off} << 1;
        if (c > 4'd9) return pc;
        if (tk) return pc + 32'd2 + disp;
        return pc + 32'd2;
    endfunction

    function automatic string req_of(input logic [3:0] c, input bit tk);
        if (c > 4'd9) return "R9";
        if (c <= 4'd1) return tk ? "R4/R7" : "R4/R8";
        if (c == 4'd2 || c == 4'd3 || c == 4'd6 || c == 4'd7) return tk ? "R5/R7" : "R5/R8";
        return tk ? "R6/R7" : "R6/R8";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle with optional compare and optional branch, result checked next cycle.
    task automatic step(input bit do_cmp, input logic [31:0] a, input logic [31:0] b,
                        input bit do_br, input logic [31:0] pc, input logic [3:0] c,
                        input logic [9:0] off, input string tag);
        bit tk;
        logic [31:0] npc;
        @(negedge clk);
        cmp_valid = do_cmp; cmp_a = a; cmp_b = b;
        br_valid = do_br; br_pc = pc; br_cond = c; br_offset = off;
        tk  = exp_taken(c, mdl_a, mdl_b);
        npc = exp_pc(c, pc, off, tk);
        if (do_cmp) begin mdl_a = a; mdl_b = b; end
        @(negedge clk);
        cmp_valid = 1'b0; br_valid = 1'b0;
        check({tag, " R10 valid"}, 64'(res_valid), 64'(do_br));
        if (do_br) begin
            check({tag, " ", req_of(c, tk), " taken"}, 64'(res_taken), 64'(tk));
            check({tag, " ", req_of(c, tk), " illegal"}, 64'(res_illegal), 64'(c > 4'd9));
            check({tag, " ", req_of(c, tk), " next_pc"}, 64'(res_next_pc), 64'(npc));
        end
    endtask

    function automatic logic [31:0] pick_operand(input logic [31:0] other);
        case ($urandom_range(0, 5))
            0: return other;
            1: return 32'h8000_0000;
            2: return 32'h7FFF_FFFF;
            3: return other + 32'd1;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 64'(res_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 64'(res_valid), 64'd0);
        check("R1 taken after reset", 64'(res_taken), 64'd0);
        check("R1 illegal after reset", 64'(res_illegal), 64'd0);
        // R1: zeroed operands make equal taken, signed less not taken
        step(0, '0, '0, 1, 32'h100, 4'd0, 10'd4, "R1 eq");
        step(0, '0, '0, 1, 32'h100, 4'd2, 10'd4, "R1 slt");
        // R2: compare only gives no result, then branches use it
        step(1, 32'h8000_0000, 32'h1, 0, '0, '0, '0, "R2 cmp only");
        step(0, '0, '0, 1, 32'h200, 4'd2, 10'd8, "R2 R5 slt");
        step(0, '0, '0, 1, 32'h200, 4'd4, 10'd8, "R2 R6 ult");
        // R3: same-cycle compare and branch uses old operands
        step(1, 32'd5, 32'd5, 1, 32'h300, 4'd0, 10'd2, "R3 same");
        step(0, '0, '0, 1, 32'h300, 4'd0, 10'd2, "R3 after");
        // R7: offset extremes and wrap
        step(0, '0, '0, 1, 32'h1000, 4'd0, 10'h1FF, "R7 max");
        step(0, '0, '0, 1, 32'h1000, 4'd0, 10'h200, "R7 min");
        step(0, '0, '0, 1, 32'h0, 4'd0, 10'h3FF, "R7 wrap");
        // R8: fallthrough wraps
        step(0, '0, '0, 1, 32'hFFFF_FFFE, 4'd1, 10'd7, "R8 wrap");
        // R9: every undefined code
        for (int c = 10; c < 16; c++)
            step(0, '0, '0, 1, 32'h4000 + 32'(c), 4'(c), 10'h155, "R9 code");
        // R10: no result one cycle later
        step(0, '0, '0, 0, '0, '0, '0, "R10 idle");
        // random mix over all codes
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            bit dc, db;
            a  = $urandom();
            b  = pick_operand(a);
            dc = ($urandom_range(0, 2) != 0);
            db = ($urandom_range(0, 3) != 0);
            step(dc, a, b, db, $urandom(), 4'($urandom_range(0, 15)),
                 10'($urandom()), "rand");
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule